// File: doc/BRIEF.md
# Interrupt cause and mask controller

This block gathers 29 single-cycle event inputs from the units of a system controller into a latched cause register and combines them into a single interrupt request for the processor. A mask register selects which sources may raise that request. Software reads both registers over a simple register port. It writes the mask directly. It acknowledges a source by writing the cause register with that source's bit at zero.

The cause word also carries three summary bits. Each summary bit is an OR over a fixed group of raw, unmasked source bits, and the groups overlap. A priority encoder reports the lowest-numbered source that is both pending and enabled, along with a valid flag. When the valid flag is low, the interrupt is treated as spurious.

Top module: `irq_cause_ctrl`

## Requirements
- R1: While reset is held and right after it, cause and mask both read 0, irq_o is low, src_vld_o is low.
- R2: A one-cycle pulse on a source event sets its cause bit on the next clock, and the bit stays set until software clears it.
- R3: A cause write (wr_en_i=1, wr_sel_i=0) clears every source bit written as 0. Bits written as 1 keep their value and are never set by the write.
- R4: If a source event arrives in the same cycle as a write that clears that source, the event wins and the bit stays set.
- R5: A mask write (wr_en_i=1, wr_sel_i=1) stores bits 29..1. Mask bits 0, 30 and 31 always read 0, whatever was written to them.
- R6: Cause read bit 0 is the OR of raw cause bits 29..1.
- R7: Cause read bit 30 is the OR of raw cause bits 29..26 and 20..1.
- R8: Cause read bit 31 is the OR of raw cause bits 25..1.
- R9: irq_o is high exactly when some cause bit in 1..29 is set and its mask bit is also 1.
- R10: src_idx_o gives the lowest bit number in 1..29 that is both set in the cause and enabled in the mask. src_vld_o is high only when such a bit exists.
- R11: event_i[j] drives cause bit j+1. rd_sel_i and wr_sel_i select the cause register with 0 and the mask register with 1. rd_data_o is combinational from the register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 29 | Source event pulses; bit j feeds cause bit j+1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 cause, 1 mask |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 cause, 1 mask |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request to the processor |
| src_idx_o | output | 5 | Lowest pending enabled source number |
| src_vld_o | output | 1 | src_idx_o is valid |

## Verification
On every cycle, the assertions check several properties. Each event sets its bit. A bit cleared by a write with no competing event drops. No bit rises without an event. Each summary bit implies the full OR. The encoded index points at a pending enabled bit with nothing pending and enabled below it. The valid flag matches the interrupt request. The bench's scenarios are the only way to show the exact group boundaries of summary bits 30 and 31, the masking of the reserved mask bits on read, and the event-over-clear collision. The bench's cycle model also checks the complete read-back values after long mixes of events and writes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W  = 32;
  localparam int SRC_LO  = 1;
  localparam int SRC_HI  = 29;
  localparam int NUM_SRC = SRC_HI - SRC_LO + 1;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int SUM_ALL = 0;
  localparam int SUM_A   = 30;
  localparam int SUM_B   = 31;

  function automatic logic [DATA_W-1:0] span(input int lo, input int hi);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = lo; k <= hi; k++) m[k] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] SRC_MASK = span(SRC_LO, SRC_HI);
  localparam logic [DATA_W-1:0] GRP_A    = span(26, 29) | span(1, 20);
  localparam logic [DATA_W-1:0] GRP_B    = span(1, 25);
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SRC_HI:SRC_LO] event_i,
  input  logic                 clr_en_i,
  input  logic [SRC_HI:SRC_LO] clr_keep_i,
  output logic [SRC_HI:SRC_LO] cause_o
);
  for (genvar k = SRC_LO; k <= SRC_HI; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else if (event_i[k]) bit_q <= 1'b1;
      else if (clr_en_i && !clr_keep_i[k]) bit_q <= 1'b0;
    end
    assign cause_o[k] = bit_q;

    a_r2_event_sets : assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_i[k] |=> cause_o[k]);
    a_r3_clear_drops : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_en_i && !clr_keep_i[k] && !event_i[k]) |=> !cause_o[k]);
    a_r3_no_spurious_set : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!event_i[k] && !cause_o[k]) |=> !cause_o[k]);
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SRC_HI:SRC_LO] cause_i,
  input  logic [SRC_HI:SRC_LO] mask_i,
  output logic                 sum_all_o,
  output logic                 sum_a_o,
  output logic                 sum_b_o,
  output logic                 irq_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 vld_o
);
  logic [DATA_W-1:0] cw, pend;

  always_comb begin
    cw = '0;
    cw[SRC_HI:SRC_LO] = cause_i;
    pend = '0;
    pend[SRC_HI:SRC_LO] = cause_i & mask_i;
  end

  assign sum_all_o = |(cw & SRC_MASK);
  assign sum_a_o   = |(cw & GRP_A);
  assign sum_b_o   = |(cw & GRP_B);
  assign irq_o     = |pend;

  // downward scan so the last hit is the lowest number
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int k = SRC_HI; k >= SRC_LO; k--) begin
      if (pend[k]) begin
        idx_o = IDX_W'(k);
        vld_o = 1'b1;
      end
    end
  end

  a_r10_idx_hits : assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> pend[idx_o]);
  a_r10_nothing_lower : assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ((pend & ((DATA_W'(1) << idx_o) - DATA_W'(1))) == '0));
  a_r9_vld_tracks_irq : assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == vld_o);
  a_r7_grp_a_in_all : assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_a_o |-> sum_all_o);
  a_r8_grp_b_in_all : assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_b_o |-> sum_all_o);
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  event_i,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_sel_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                irq_o,
  output logic [IDX_W-1:0]    src_idx_o,
  output logic                src_vld_o
);
  logic [SRC_HI:SRC_LO] ev_w, cause_w, mask_q;
  logic sum_all, sum_a, sum_b;
  logic unused_bits;

  assign ev_w = event_i;
  assign unused_bits = ^{wr_data_i[SUM_B:SUM_A], wr_data_i[SUM_ALL]};

  irq_cause_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (ev_w),
    .clr_en_i   (wr_en_i && !wr_sel_i),
    .clr_keep_i (wr_data_i[SRC_HI:SRC_LO]),
    .cause_o    (cause_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (wr_en_i && wr_sel_i) mask_q <= wr_data_i[SRC_HI:SRC_LO];
  end

  irq_summary u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cause_i   (cause_w),
    .mask_i    (mask_q),
    .sum_all_o (sum_all),
    .sum_a_o   (sum_a),
    .sum_b_o   (sum_b),
    .irq_o     (irq_o),
    .idx_o     (src_idx_o),
    .vld_o     (src_vld_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i) begin
      rd_data_o[SRC_HI:SRC_LO] = mask_q;
    end else begin
      rd_data_o[SRC_HI:SRC_LO] = cause_w;
      rd_data_o[SUM_ALL] = sum_all;
      rd_data_o[SUM_A]   = sum_a;
      rd_data_o[SUM_B]   = sum_b;
    end
  end

  a_r5_mask_write_lands : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (mask_q == $past(wr_data_i[SRC_HI:SRC_LO])));
  a_r9_irq_needs_cause : assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sum_all);
endmodule

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] SRCM = 32'h3FFF_FFFE;
  localparam logic [31:0] GA   = 32'h3C1F_FFFE;
  localparam logic [31:0] GB   = 32'h03FF_FFFE;

  logic clk = 0, rst_n = 0;
  logic [28:0] ev = '0;
  logic we = 0, ws = 0, rs = 0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic irq, vld;
  logic [4:0] idx;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] m_cause = '0, m_mask = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_cause_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .wr_en_i(we), .wr_sel_i(ws),
    .wr_data_i(wd), .rd_sel_i(rs), .rd_data_o(rd), .irq_o(irq),
    .src_idx_o(idx), .src_vld_o(vld)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] c, p;
    int lo;
    c = m_cause & SRCM;
    p = c & m_mask;
    lo = 0;
    for (int k = 29; k >= 1; k--) if (p[k]) lo = k;
    if (rs) chk("R5 mask read", rd, m_mask & SRCM);
    else begin
      chk("R2 R3 R4 R11 cause bits", rd & SRCM, c);
      chk("R6 summary bit0", {31'd0, rd[0]}, {31'd0, |c});
      chk("R7 summary bit30", {31'd0, rd[30]}, {31'd0, |(c & GA)});
      chk("R8 summary bit31", {31'd0, rd[31]}, {31'd0, |(c & GB)});
    end
    chk("R9 irq", {31'd0, irq}, {31'd0, |p});
    chk("R10 valid", {31'd0, vld}, {31'd0, lo != 0});
    if (lo != 0) chk("R10 index", {27'd0, idx}, lo);
  endtask

  // drive at negedge, compare, then model the next edge
  task automatic step(input logic [28:0] e, input logic w, input logic s,
                      input logic [31:0] d, input logic r);
    @(negedge clk);
    ev = e; we = w; ws = s; wd = d; rs = r;
    #1 compare();
    @(posedge clk);
    for (int k = 1; k <= 29; k++)
      m_cause[k] = e[k-1] | (m_cause[k] & !(w && !s && !d[k]));
    if (w && s) m_mask = d & SRCM;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rs = 0; #1;
    chk("R1 reset cause", rd, 32'd0);
    chk("R1 reset irq", {30'd0, irq, vld}, 32'd0);
    rs = 1; #1;
    chk("R1 reset mask", rd, 32'd0);
    @(negedge clk) rst_n = 1;
    step('0, 0, 0, '0, 0);
    // R7: bit 26 in group A only; R8: bit 21 in group B only
    step(29'(1) << 25, 0, 0, '0, 0);
    step('0, 0, 0, '0, 0);
    step('0, 1, 0, ~(32'd1 << 26), 0);
    step(29'(1) << 20, 0, 0, '0, 0);
    step('0, 0, 0, '0, 0);
    // R3: writing all ones sets nothing
    step('0, 1, 0, 32'hFFFF_FFFF, 0);
    step('0, 0, 0, '0, 0);
    // R4: event at bit 5 while clearing it
    step(29'(1) << 4, 1, 0, 32'd0, 0);
    step('0, 0, 0, '0, 0);
    // R5: reserved mask bits ignored
    step('0, 1, 1, 32'hFFFF_FFFF, 1);
    step('0, 0, 0, '0, 1);
    // R10: several pending, lowest wins, then walk up
    step(29'h0010_0101, 0, 0, '0, 0);
    step('0, 0, 0, '0, 0);
    step('0, 1, 0, ~(32'd1 << 5), 0);
    step('0, 1, 0, ~(32'd1 << 1), 0);
    step('0, 1, 1, 32'h0000_0200, 1);
    step('0, 0, 0, '0, 0);
    step('0, 1, 1, 32'd0, 0);
    step('0, 0, 0, '0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [28:0] e;
      logic w;
      e = ($urandom_range(0, 3) == 0) ? (29'(1) << $urandom_range(0, 28)) : '0;
      w = ($urandom_range(0, 4) == 0);
      step(e, w, 1'($urandom), $urandom, 1'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule